// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Master

This block runs a serial EEPROM that holds 16-bit words at 8-bit addresses. It uses a chip select, a serial clock and a data line that it drives, and it samples the return data line from the device. A host starts one operation at a time by pulsing a request with an address, a direction and, for writes, a data word. It then waits for a one-cycle completion pulse. A read returns the word on the completion pulse. A write runs a fixed sequence without further help from the host: an unlock frame, the data frame, a readiness poll of the device and a relock frame.

Every serial bit has three phases, and each phase lasts `PHASE_DIV` system clocks. In the first phase the data line is set while select is high and the clock is low. In the second phase the clock is high. In the third phase the clock is low again. Chip select goes low for one phase between any two frames. After a data frame the device is selected again with the clock idle, and its return line is sampled once per phase until it reads high. If it is not ready after `poll_limit` samples, the block gives up. The relock frame is still sent, and the error flag is raised together with the completion pulse.

Top module: `ser_eeprom_master`

## Requirements
- R1: While reset is held and after it is released with no request, ee_cs, ee_sk, ee_dout, busy and done are all 0.
- R2: ee_dout never changes while ee_sk is high, and every high phase of ee_sk lasts at least PHASE_DIV clocks.
- R3: A read sends 11 bits MSB first: start bit 1, opcode 10, then the address. It then gives 16 clock pulses and shifts in ee_din MSB first, sampling while ee_sk is high. The word appears on rdata in the cycle done is high.
- R4: A write sends the unlock frame 1,00,11111111 first. It then sends a 27-bit frame MSB first: start bit 1, opcode 01, the address, then the 16 data bits.
- R5: After the data frame, select goes low, then goes high again with ee_sk low. ee_din is sampled once per phase until it reads 1, and the write then completes with timeout_err at 0.
- R6: If poll_limit samples all read 0, the poll stops and timeout_err is 1 in the cycle done pulses. A poll_limit of 0 acts as 1.
- R7: Every write, including one that timed out, ends with the relock frame 1,00,00000000 before done.
- R8: ee_sk is high only while ee_cs is high, and ee_cs stays low for at least PHASE_DIV clocks between frames.
- R9: A request is taken only while busy is 0. A request raised while busy is ignored and never reaches the device.
- R10: busy rises in the cycle after a request is accepted and falls in the cycle done pulses. done is high for exactly one cycle per accepted request.
- R11: timeout_err holds its value until the next accepted request, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Start an operation (taken when busy is 0) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Word address |
| req_wdata | input | 16 | Word to write |
| poll_limit | input | POLL_W | Largest number of readiness samples before giving up |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read word, valid while done is high |
| timeout_err | output | 1 | Last write gave up on the readiness poll |
| ee_cs | output | 1 | Device select, active high |
| ee_sk | output | 1 | Serial clock |
| ee_dout | output | 1 | Serial data to the device |
| ee_din | input | 1 | Serial data and ready status from the device |

## Verification
The assertions assume three things. The host only raises req with stable fields. poll_limit does not change while an operation runs. PHASE_DIV is at least 2, so the device can react to a rising serial clock before the sample point. The bench drives req only on falling system clock edges and holds poll_limit constant for the whole of each operation. Its behavioural device answers within one clock of each rising ee_sk edge. Device busy times are set both well inside and well beyond the poll window, so both the successful poll and the timeout path are covered.

// File: rtl/seeprom_pkg.sv
// Package: shared sizes, opcodes and frame builders for the serial EEPROM master.
// Assumes 8-bit word addresses, 16-bit words, and frames left-aligned in a 27-bit shifter.
package seeprom_pkg;
    localparam int ADDR_W  = 8;
    localparam int WORD_W  = 16;
    localparam int HDR_W   = 3 + ADDR_W;
    localparam int FRAME_W = HDR_W + WORD_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_CTRL  = 2'b00;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_UNLOCK, SQ_DATA, SQ_POLL, SQ_RELOCK, SQ_READ
    } seq_state_t;

    typedef enum logic [2:0] {
        EG_IDLE, EG_SETUP, EG_HIGH, EG_LOW, EG_POLL, EG_DESEL
    } eng_state_t;

    function automatic logic [FRAME_W-1:0] frm_read(input logic [ADDR_W-1:0] a);
        return {1'b1, OPC_READ, a, {WORD_W{1'b0}}};
    endfunction

    function automatic logic [FRAME_W-1:0] frm_write(input logic [ADDR_W-1:0] a,
                                                     input logic [WORD_W-1:0] d);
        return {1'b1, OPC_WRITE, a, d};
    endfunction

    function automatic logic [FRAME_W-1:0] frm_unlock();
        return {1'b1, OPC_CTRL, {ADDR_W{1'b1}}, {WORD_W{1'b0}}};
    endfunction

    function automatic logic [FRAME_W-1:0] frm_relock();
        return {1'b1, OPC_CTRL, {ADDR_W{1'b0}}, {WORD_W{1'b0}}};
    endfunction
endpackage

// File: rtl/seeprom_phase_timer.sv
// Module: phase timer. Gives a one-cycle tick every DIV clocks while run is high.
// Assumes the counter restarts from zero each time run rises, so the first phase is a full one.
module seeprom_phase_timer #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    // Count clocks within the current phase; hold at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)            cnt <= '0;
        else if (cnt == CW'(DIV - 1))  cnt <= '0;
        else                           cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == CW'(DIV - 1));

    generate
        if (DIV > 1) begin : g_spacing
            assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/seeprom_frame_engine.sv
// Module: frame engine. Shifts out one frame MSB first and optionally shifts in a word,
// or runs a readiness poll. Ends every job with one deselect phase and a done pulse.
// Assumes start arrives only while the engine is idle and poll_limit holds during a poll.
module seeprom_frame_engine
    import seeprom_pkg::*;
#(
    parameter int DIV    = 4,
    parameter int POLL_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               poll_mode,
    input  logic [FRAME_W-1:0] frame,
    input  logic [CNT_W-1:0]   out_bits,
    input  logic [CNT_W-1:0]   in_bits,
    input  logic [POLL_W-1:0]  poll_limit,
    input  logic               din,
    output logic               cs,
    output logic               sk,
    output logic               dout,
    output logic               done,
    output logic               fail,
    output logic [WORD_W-1:0]  rdata
);
    eng_state_t         st;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   out_left;
    logic [CNT_W-1:0]   in_left;
    logic [POLL_W-1:0]  polls;
    logic               tick;
    logic [POLL_W-1:0]  limit_eff;
    logic [POLL_W:0]    polls_nx;

    seeprom_phase_timer #(.DIV(DIV)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (st != EG_IDLE),
        .tick (tick)
    );

    assign limit_eff = (poll_limit == '0) ? {{(POLL_W-1){1'b0}}, 1'b1} : poll_limit;
    assign polls_nx  = {1'b0, polls} + {{POLL_W{1'b0}}, 1'b1};

    // Step through the three phases of each bit, the poll samples and the closing deselect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= EG_IDLE;
            shreg    <= '0;
            out_left <= '0;
            in_left  <= '0;
            polls    <= '0;
            done     <= 1'b0;
            fail     <= 1'b0;
            rdata    <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                EG_IDLE: if (start) begin
                    shreg    <= frame;
                    out_left <= out_bits;
                    in_left  <= in_bits;
                    polls    <= '0;
                    fail     <= 1'b0;
                    if (!poll_mode) rdata <= '0;
                    st <= poll_mode ? EG_POLL : EG_SETUP;
                end
                EG_SETUP: if (tick) st <= EG_HIGH;
                EG_HIGH: if (tick) begin
                    if (out_left == '0) rdata <= {rdata[WORD_W-2:0], din};
                    st <= EG_LOW;
                end
                EG_LOW: if (tick) begin
                    if (out_left != '0) begin
                        out_left <= out_left - 1'b1;
                        shreg    <= shreg << 1;
                        st <= (out_left == CNT_W'(1) && in_left == '0) ? EG_DESEL : EG_SETUP;
                    end else begin
                        in_left <= in_left - 1'b1;
                        st <= (in_left == CNT_W'(1)) ? EG_DESEL : EG_SETUP;
                    end
                end
                EG_POLL: if (tick) begin
                    if (din) begin
                        st <= EG_DESEL;
                    end else if (polls_nx >= {1'b0, limit_eff}) begin
                        fail <= 1'b1;
                        st   <= EG_DESEL;
                    end else begin
                        polls <= polls_nx[POLL_W-1:0];
                    end
                end
                EG_DESEL: if (tick) begin
                    st   <= EG_IDLE;
                    done <= 1'b1;
                end
                default: st <= EG_IDLE;
            endcase
        end
    end

    // Decode the pin levels from the phase state.
    always_comb begin
        cs   = (st == EG_SETUP) || (st == EG_HIGH) || (st == EG_LOW) || (st == EG_POLL);
        sk   = (st == EG_HIGH);
        dout = ((st == EG_SETUP) || (st == EG_HIGH) || (st == EG_LOW))
               && (out_left != '0) && shreg[FRAME_W-1];
    end

    assert_sk_inside_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sk |-> cs);
    assert_dout_steady_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sk && $past(sk)) |-> $stable(dout));
    assert_poll_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == EG_POLL) |-> ({1'b0, polls} < {1'b0, limit_eff}));
    assert_start_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (st == EG_IDLE));
endmodule

// File: rtl/ser_eeprom_master.sv
// Module: top of the serial EEPROM master. Takes one host request at a time and runs
// either a read frame, or the unlock / data / poll / relock sequence for a write.
// Assumes the host keeps poll_limit steady during an operation and PHASE_DIV >= 2.
module ser_eeprom_master
    import seeprom_pkg::*;
#(
    parameter int PHASE_DIV = 4,
    parameter int POLL_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_write,
    input  logic [7:0]        req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [POLL_W-1:0] poll_limit,
    output logic              busy,
    output logic              done,
    output logic [15:0]       rdata,
    output logic              timeout_err,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_dout,
    input  logic              ee_din
);
    localparam logic [CNT_W-1:0] HDR_BITS = CNT_W'(HDR_W);
    localparam logic [CNT_W-1:0] FRM_BITS = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] WRD_BITS = CNT_W'(WORD_W);

    seq_state_t         st;
    logic [ADDR_W-1:0]  addr_q;
    logic [WORD_W-1:0]  data_q;
    logic               start_q;
    logic               poll_q;
    logic [FRAME_W-1:0] frame_q;
    logic [CNT_W-1:0]   out_q;
    logic [CNT_W-1:0]   in_q;
    logic               tout_q;
    logic               eng_done;
    logic               eng_fail;
    logic [WORD_W-1:0]  eng_rdata;

    seeprom_frame_engine #(.DIV(PHASE_DIV), .POLL_W(POLL_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_q),
        .poll_mode (poll_q),
        .frame     (frame_q),
        .out_bits  (out_q),
        .in_bits   (in_q),
        .poll_limit(poll_limit),
        .din       (ee_din),
        .cs        (ee_cs),
        .sk        (ee_sk),
        .dout      (ee_dout),
        .done      (eng_done),
        .fail      (eng_fail),
        .rdata     (eng_rdata)
    );

    // Sequence the frames of one operation and hand each to the engine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= SQ_IDLE;
            addr_q      <= '0;
            data_q      <= '0;
            start_q     <= 1'b0;
            poll_q      <= 1'b0;
            frame_q     <= '0;
            out_q       <= '0;
            in_q        <= '0;
            tout_q      <= 1'b0;
            done        <= 1'b0;
            rdata       <= '0;
            timeout_err <= 1'b0;
        end else begin
            start_q <= 1'b0;
            done    <= 1'b0;
            case (st)
                SQ_IDLE: if (req) begin
                    addr_q      <= req_addr;
                    data_q      <= req_wdata;
                    timeout_err <= 1'b0;
                    tout_q      <= 1'b0;
                    start_q     <= 1'b1;
                    poll_q      <= 1'b0;
                    out_q       <= HDR_BITS;
                    if (req_write) begin
                        frame_q <= frm_unlock();
                        in_q    <= '0;
                        st      <= SQ_UNLOCK;
                    end else begin
                        frame_q <= frm_read(req_addr);
                        in_q    <= WRD_BITS;
                        st      <= SQ_READ;
                    end
                end
                SQ_UNLOCK: if (eng_done) begin
                    start_q <= 1'b1;
                    frame_q <= frm_write(addr_q, data_q);
                    out_q   <= FRM_BITS;
                    in_q    <= '0;
                    st      <= SQ_DATA;
                end
                SQ_DATA: if (eng_done) begin
                    start_q <= 1'b1;
                    poll_q  <= 1'b1;
                    st      <= SQ_POLL;
                end
                SQ_POLL: if (eng_done) begin
                    tout_q  <= eng_fail;
                    start_q <= 1'b1;
                    poll_q  <= 1'b0;
                    frame_q <= frm_relock();
                    out_q   <= HDR_BITS;
                    in_q    <= '0;
                    st      <= SQ_RELOCK;
                end
                SQ_RELOCK: if (eng_done) begin
                    done        <= 1'b1;
                    timeout_err <= tout_q;
                    st          <= SQ_IDLE;
                end
                SQ_READ: if (eng_done) begin
                    done  <= 1'b1;
                    rdata <= eng_rdata;
                    st    <= SQ_IDLE;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assign busy = (st != SQ_IDLE);

    assert_done_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_busy_ends_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && !busy) |-> done);
    assert_err_rises_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> done);
    assert_busy_request_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req) |=> $stable(addr_q));
endmodule

// File: tb/tb_ser_eeprom_master.sv
`timescale 1ns/1ps
module tb_ser_eeprom_master;
    localparam int DIV    = 4;
    localparam int POLL_W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic              req = 1'b0;
    logic              req_write = 1'b0;
    logic [7:0]        req_addr = '0;
    logic [15:0]       req_wdata = '0;
    logic [POLL_W-1:0] poll_limit = 12'd1000;
    logic              busy, done, timeout_err, ee_cs, ee_sk, ee_dout;
    logic              ee_din;
    logic [15:0]       rdata;

    ser_eeprom_master #(.PHASE_DIV(DIV), .POLL_W(POLL_W)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .poll_limit(poll_limit),
        .busy(busy), .done(done), .rdata(rdata), .timeout_err(timeout_err),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_dout(ee_dout), .ee_din(ee_din)
    );

    int checks = 0;
    int errors = 0;
    int completed = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Behavioural device: decodes frames, answers reads, reports ready after a busy time.
    logic [15:0] mem [256];
    logic        prev_sk, prev_cs, prev_dout;
    logic [26:0] sh;
    int bitcnt, rd_k, dbusy, busy_cfg;
    bit rd_active, wen;
    logic [15:0] rd_word;
    int en_cnt, wr_cnt, dis_cnt, rd_cnt, poll_frames, proto_err;
    int sk_len, cs_low_len, sk_short, dout_moves, gap_short;

    initial busy_cfg = 40;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
            prev_sk = 0; prev_cs = 0; prev_dout = 0; sh = '0; bitcnt = 0; rd_k = 0;
            dbusy = 0; rd_active = 0; wen = 0; rd_word = '0;
            en_cnt = 0; wr_cnt = 0; dis_cnt = 0; rd_cnt = 0; poll_frames = 0; proto_err = 0;
            sk_len = 0; cs_low_len = 100; sk_short = 0; dout_moves = 0; gap_short = 0;
            ee_din <= 1'b0;
        end else begin
            if (ee_sk && prev_sk && ee_dout !== prev_dout) dout_moves++;
            if (ee_sk) sk_len++;
            if (!ee_sk && prev_sk) begin
                if (sk_len < DIV) sk_short++;
                sk_len = 0;
            end
            if (!ee_cs) cs_low_len++;
            if (ee_cs && !prev_cs) begin
                if (cs_low_len < DIV) gap_short++;
                cs_low_len = 0;
            end
            if (dbusy > 0) dbusy--;
            if (ee_sk && !prev_sk && ee_cs) begin
                if (rd_active) begin
                    ee_din <= rd_word[15 - rd_k];
                    rd_k++;
                end else begin
                    sh = {sh[25:0], ee_dout};
                    bitcnt++;
                    if (bitcnt == 11 && sh[10:8] == 3'b110) begin
                        rd_active = 1;
                        rd_word = mem[sh[7:0]];
                        rd_k = 0;
                    end
                end
            end else if (!rd_active) begin
                ee_din <= (dbusy == 0);
            end
            if (prev_cs && !ee_cs) begin
                if (rd_active) begin
                    if (rd_k == 16) rd_cnt++; else proto_err++;
                end else if (bitcnt == 11 && sh[10:0] == 11'b100_11111111) begin
                    wen = 1; en_cnt++;
                end else if (bitcnt == 11 && sh[10:0] == 11'b100_00000000) begin
                    wen = 0; dis_cnt++;
                end else if (bitcnt == 27 && sh[26:24] == 3'b101) begin
                    if (!wen) proto_err++;
                    mem[sh[23:16]] = sh[15:0];
                    wr_cnt++;
                    dbusy = busy_cfg;
                end else if (bitcnt == 0) begin
                    poll_frames++;
                end else begin
                    proto_err++;
                end
                bitcnt = 0; sh = '0; rd_active = 0;
            end
            prev_sk = ee_sk; prev_cs = ee_cs; prev_dout = ee_dout;
        end
    end

    // Scoreboard: the driver pushes expectations, the monitor pops them on done.
    typedef struct {
        bit          is_rd;
        logic [15:0] data;
        bit          tout;
    } exp_t;
    exp_t sbq[$];
    logic [15:0] shadow [256];

    always @(negedge clk) begin
        if (rst_n && done) begin
            exp_t e;
            if (sbq.size() == 0) begin
                chk(0, "R10", "done without request", 1, 0);
            end else begin
                e = sbq.pop_front();
                if (e.is_rd) chk(rdata == e.data, "R3", "read word", rdata, e.data);
                chk(timeout_err == e.tout, "R6", "timeout flag at done", timeout_err, e.tout);
                completed++;
            end
        end
    end

    task automatic run_op(input bit wr, input logic [7:0] a, input logic [15:0] d,
                          input bit exp_tout, input bit poke);
        int n0;
        exp_t e;
        n0 = completed;
        while (busy) @(negedge clk);
        @(negedge clk);
        req = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        e.is_rd = !wr; e.tout = exp_tout;
        if (wr) begin
            shadow[a] = d;
            e.data = '0;
        end else begin
            e.data = shadow[a];
        end
        sbq.push_back(e);
        @(negedge clk);
        req = 1'b0;
        chk(busy == 1'b1, "R10", "busy after accept", busy, 1);
        chk(timeout_err == 1'b0, "R11", "error cleared on accept", timeout_err, 0);
        if (poke) begin
            repeat (40) @(negedge clk);
            req = 1'b1; req_write = 1'b1; req_addr = 8'h20; req_wdata = 16'h7777;
            @(negedge clk);
            req = 1'b0;
        end
        while (completed == n0) @(negedge clk);
    endtask

    initial begin
        int en0, wr0, dis0, pf0;
        for (int i = 0; i < 256; i++) shadow[i] = 16'h0000;
        repeat (5) @(negedge clk);
        chk({ee_cs, ee_sk, ee_dout, busy, done} == 5'b0, "R1", "pins in reset",
            {ee_cs, ee_sk, ee_dout, busy, done}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk({ee_cs, ee_sk, ee_dout, busy, done} == 5'b0, "R1", "pins idle after reset",
            {ee_cs, ee_sk, ee_dout, busy, done}, 0);

        // R4 R7: write wrapped in unlock and relock frames
        en0 = en_cnt; wr0 = wr_cnt; dis0 = dis_cnt;
        run_op(1, 8'h00, 16'h1234, 0, 0);
        chk(en_cnt - en0 == 1, "R4", "unlock frames", en_cnt - en0, 1);
        chk(wr_cnt - wr0 == 1, "R4", "data frames", wr_cnt - wr0, 1);
        chk(dis_cnt - dis0 == 1, "R7", "relock frames", dis_cnt - dis0, 1);
        chk(wen == 0, "R7", "device relocked", wen, 0);
        run_op(0, 8'h00, 16'h0, 0, 0);

        run_op(1, 8'hFF, 16'hFFFF, 0, 0);
        run_op(1, 8'h5A, 16'h0000, 0, 0);
        run_op(1, 8'hA5, 16'hA5C3, 0, 0);
        run_op(0, 8'hFF, 16'h0, 0, 0);
        run_op(0, 8'hA5, 16'h0, 0, 0);
        run_op(0, 8'h5A, 16'h0, 0, 0);
        run_op(0, 8'h33, 16'h0, 0, 0);

        // R5: long device busy time inside the poll window
        busy_cfg = 200; pf0 = poll_frames;
        run_op(1, 8'h81, 16'h8001, 0, 0);
        chk(poll_frames - pf0 == 1, "R5", "one poll selection", poll_frames - pf0, 1);
        run_op(0, 8'h81, 16'h0, 0, 0);

        // R6 R7: poll window too short, relock still sent
        busy_cfg = 400; poll_limit = 12'd5; dis0 = dis_cnt;
        run_op(1, 8'h42, 16'h4242, 1, 0);
        chk(timeout_err == 1'b1, "R6", "error held after done", timeout_err, 1);
        chk(dis_cnt - dis0 == 1, "R7", "relock after timeout", dis_cnt - dis0, 1);
        chk(wen == 0, "R7", "device relocked after timeout", wen, 0);
        while (dbusy > 0) @(negedge clk);
        poll_limit = 12'd1000; busy_cfg = 40;

        // R11: next operation clears the error
        run_op(0, 8'h42, 16'h0, 0, 0);
        chk(timeout_err == 1'b0, "R11", "error after next op", timeout_err, 0);

        // R9: request raised mid-operation is ignored
        wr0 = wr_cnt;
        run_op(1, 8'h10, 16'hBEEF, 0, 1);
        chk(wr_cnt - wr0 == 1, "R9", "only one data frame", wr_cnt - wr0, 1);
        repeat (10) @(negedge clk);
        chk(busy == 1'b0, "R9", "idle after ignored request", busy, 0);
        run_op(0, 8'h20, 16'h0, 0, 0);
        run_op(0, 8'h10, 16'h0, 0, 0);

        chk(sbq.size() == 0, "R10", "all expectations consumed", sbq.size(), 0);
        chk(dout_moves == 0, "R2", "data moved while clock high", dout_moves, 0);
        chk(sk_short == 0, "R2", "short clock high phases", sk_short, 0);
        chk(gap_short == 0, "R8", "short deselect gaps", gap_short, 0);
        chk(proto_err == 0, "R3", "malformed frames", proto_err, 0);
        chk(rd_cnt >= 9, "R3", "read frames seen", rd_cnt, 9);
        wrap_up();
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "R10", "watchdog expired", 1, 0);
        wrap_up();
    end
endmodule